// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Generator

This block watches the access signals of both ports of a shared dual-port memory and turns writes to its two highest word addresses into interrupts between the ports. The highest address is the left-to-right mailbox. When the left port writes it, the right-side interrupt goes low, and it stays low until the right port reads that word. The address just below it is the right-to-left mailbox and works the same way in the other direction. The storage array is outside the block, so the mailbox words keep their data and can be read and written like any other memory location.

A global enable turns the feature on and off. When it is low, both flags are held clear and the two top words are ordinary storage. All inputs are sampled on the rising clock edge. An output changes on the edge that samples the access that caused the change.

Top module: `mbx_irq_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both `l_irq_n` and `r_irq_n` are high.
- R2: With `irq_en` high, a left access (`l_cs_n`=0, `l_rw`=0 meaning write) to the all-ones address drives `r_irq_n` low after that edge.
- R3: With `irq_en` high, a right read (`r_cs_n`=0, `r_rw`=1) of the all-ones address returns `r_irq_n` high after that edge.
- R4: With `irq_en` high, a right write to the all-ones address minus one drives `l_irq_n` low after that edge.
- R5: With `irq_en` high, a left read of the all-ones address minus one returns `l_irq_n` high after that edge.
- R6: When a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R7: No other access changes a flag. This covers other addresses, the wrong direction, a sender rewriting its own mailbox and a receiver writing the mailbox.
- R8: While `irq_en` is low, no flag is set and both flags are cleared, so both outputs are high from the next edge on.
- R9: An access with its chip select high (`l_cs_n` or `r_cs_n` = 1) has no effect, whatever its address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_en | input | 1 | Mailbox interrupt feature enable |
| l_cs_n | input | 1 | Left port select, active low |
| l_rw | input | 1 | Left port direction, 1 read, 0 write |
| l_addr | input | ADDR_W | Left port word address |
| r_cs_n | input | 1 | Right port select, active low |
| r_rw | input | 1 | Right port direction, 1 read, 0 write |
| r_addr | input | ADDR_W | Right port word address |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
The assertions check on every cycle the following: each set, each clear, set-over-clear priority, holding when there is no relevant access, and the forced clear while disabled. They relate the sampled port accesses to each output one edge later. The bench scenarios cover what depends on a sequence of accesses: several messages in a row, a rewrite of a mailbox while the interrupt is pending, turning the feature off and back on in the middle of a message, and a reset in the middle of a run. The randomized stimulus is weighted toward the two mailbox addresses so that collisions on both sides occur often.

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              l_cs_n,
  input  logic              l_rw,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_cs_n,
  input  logic              r_rw,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] TO_R_ADDR = '1;
  localparam logic [ADDR_W-1:0] TO_L_ADDR = TO_R_ADDR - 1'b1;

  logic to_r_flag, to_l_flag;
  logic to_r_set, to_r_clr, to_l_set, to_l_clr;

  assign to_r_set = !l_cs_n && !l_rw && (l_addr == TO_R_ADDR);
  assign to_r_clr = !r_cs_n &&  r_rw && (r_addr == TO_R_ADDR);
  assign to_l_set = !r_cs_n && !r_rw && (r_addr == TO_L_ADDR);
  assign to_l_clr = !l_cs_n &&  l_rw && (l_addr == TO_L_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_r_flag <= 1'b0;
      to_l_flag <= 1'b0;
    end else if (!irq_en) begin
      to_r_flag <= 1'b0;
      to_l_flag <= 1'b0;
    end else begin
      if (to_r_set)      to_r_flag <= 1'b1;
      else if (to_r_clr) to_r_flag <= 1'b0;
      if (to_l_set)      to_l_flag <= 1'b1;
      else if (to_l_clr) to_l_flag <= 1'b0;
    end
  end

  assign r_irq_n = ~to_r_flag;
  assign l_irq_n = ~to_l_flag;
endmodule

module mbx_irq_gen_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_en,
  input logic              l_cs_n,
  input logic              l_rw,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_cs_n,
  input logic              r_rw,
  input logic [ADDR_W-1:0] r_addr,
  input logic              l_irq_n,
  input logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] HI = '1;
  localparam logic [ADDR_W-1:0] LO = HI - 1'b1;

  logic lw_hi, rr_hi, rw_lo, lr_lo;
  assign lw_hi = !l_cs_n && !l_rw && l_addr == HI;
  assign rr_hi = !r_cs_n &&  r_rw && r_addr == HI;
  assign rw_lo = !r_cs_n && !r_rw && r_addr == LO;
  assign lr_lo = !l_cs_n &&  l_rw && l_addr == LO;

  a_r1_reset_high: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));
  a_r2_right_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && lw_hi) |=> !r_irq_n);
  a_r3_right_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rr_hi && !lw_hi) |=> r_irq_n);
  a_r4_left_set: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && rw_lo) |=> !l_irq_n);
  a_r5_left_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && lr_lo && !rw_lo) |=> l_irq_n);
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && lw_hi && rr_hi) |=> !r_irq_n);
  a_r7_right_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !lw_hi && !rr_hi) |=> $stable(r_irq_n));
  a_r7_left_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && !rw_lo && !lr_lo) |=> $stable(l_irq_n));
  a_r8_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |=> (l_irq_n && r_irq_n));
endmodule

bind mbx_irq_gen mbx_irq_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
  .l_cs_n(l_cs_n), .l_rw(l_rw), .l_addr(l_addr),
  .r_cs_n(r_cs_n), .r_rw(r_rw), .r_addr(r_addr),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/sim_mbx_irq_gen.sv
module sim_mbx_irq_gen;
  localparam int AW = 14;
  localparam logic [AW-1:0] HI = '1;
  localparam logic [AW-1:0] LO = HI - 1'b1;

  logic clk = 1'b0;
  logic rst_n, irq_en, l_cs_n, l_rw, r_cs_n, r_rw;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int n_chk = 0, n_fail = 0;
  bit exp_l = 1'b0, exp_r = 1'b0;
  string tag_l = "R1", tag_r = "R1";
  bit finished = 1'b0;

  always #2 clk = ~clk;

  mbx_irq_gen #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
    .l_cs_n(l_cs_n), .l_rw(l_rw), .l_addr(l_addr),
    .r_cs_n(r_cs_n), .r_rw(r_rw), .r_addr(r_addr),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  function automatic bit next_flag(bit cur, bit en, bit set, bit clr);
    if (!en) return 1'b0;
    if (set) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  function automatic string pick_tag(bit rst, bit en, bit set, bit clr, bit idle_hit,
                                     string s_set, string s_clr);
    if (!rst) return "R1";
    if (!en) return "R8";
    if (set && clr) return "R6";
    if (set) return s_set;
    if (clr) return s_clr;
    if (idle_hit) return "R9";
    return "R7";
  endfunction

  task automatic compare();
    n_chk += 2;
    if (r_irq_n !== ~exp_r) begin
      n_fail++;
      $display("FAIL %s r_irq_n actual=%b expected=%b", tag_r, r_irq_n, ~exp_r);
    end
    if (l_irq_n !== ~exp_l) begin
      n_fail++;
      $display("FAIL %s l_irq_n actual=%b expected=%b", tag_l, l_irq_n, ~exp_l);
    end
  endtask

  task automatic step(input bit rst, input bit en,
                      input bit lcs, input bit lrw, input logic [AW-1:0] la,
                      input bit rcs, input bit rrw, input logic [AW-1:0] ra);
    bit ls, lc, rs, rc, l_idle, r_idle;
    @(negedge clk);
    compare();
    rst_n = rst; irq_en = en;
    l_cs_n = lcs; l_rw = lrw; l_addr = la;
    r_cs_n = rcs; r_rw = rrw; r_addr = ra;
    rs = !lcs && !lrw && la == HI;
    rc = !rcs &&  rrw && ra == HI;
    ls = !rcs && !rrw && ra == LO;
    lc = !lcs &&  lrw && la == LO;
    r_idle = (lcs && la == HI) || (rcs && ra == HI);
    l_idle = (lcs && la == LO) || (rcs && ra == LO);
    tag_r = pick_tag(rst, en, rs, rc, r_idle, "R2", "R3");
    tag_l = pick_tag(rst, en, ls, lc, l_idle, "R4", "R5");
    if (!rst) begin exp_r = 1'b0; exp_l = 1'b0; end
    else begin
      exp_r = next_flag(exp_r, en, rs, rc);
      exp_l = next_flag(exp_l, en, ls, lc);
    end
  endtask

  function automatic logic [AW-1:0] rnd_addr();
    int k = $urandom_range(0, 3);
    if (k == 0) return HI;
    if (k == 1) return LO;
    if (k == 2) return HI - 2;
    return AW'($urandom);
  endfunction

  initial begin
    #400000;
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; irq_en = 1'b1;
    l_cs_n = 1'b1; l_rw = 1'b1; l_addr = '0;
    r_cs_n = 1'b1; r_rw = 1'b1; r_addr = '0;
    // R1 reset state
    step(0, 1, 0, 0, HI, 0, 0, LO);
    step(0, 1, 0, 0, HI, 0, 0, LO);
    step(1, 1, 1, 1, 0, 1, 1, 0);
    // R2, R3 left to right message
    step(1, 1, 0, 0, HI, 1, 1, 0);
    step(1, 1, 0, 0, HI, 0, 0, HI);   // R7 sender rewrite and receiver write
    step(1, 1, 1, 1, 0, 0, 1, HI);
    // R4, R5 right to left message
    step(1, 1, 1, 1, 0, 0, 0, LO);
    step(1, 1, 0, 0, LO, 1, 1, 0);    // R7 receiver write
    step(1, 1, 0, 1, LO, 1, 1, 0);
    // R6 set and clear together
    step(1, 1, 0, 0, HI, 0, 1, HI);
    step(1, 1, 0, 1, LO, 0, 0, LO);
    // R9 deselected accesses on mailbox addresses
    step(1, 1, 1, 0, HI, 1, 0, LO);
    step(1, 1, 1, 1, LO, 1, 1, HI);
    // R8 disable while pending, then accesses while disabled
    step(1, 0, 1, 1, 0, 1, 1, 0);
    step(1, 0, 0, 0, HI, 0, 0, LO);
    step(1, 1, 1, 1, 0, 1, 1, 0);
    for (int i = 0; i < 3000; i++) begin
      bit en = ($urandom_range(0, 15) != 0);
      bit rs = ($urandom_range(0, 199) != 0);
      step(rs, en, $urandom_range(0, 3) == 0, $urandom_range(0, 1),
           rnd_addr(), $urandom_range(0, 3) == 0, $urandom_range(0, 1), rnd_addr());
    end
    step(1, 1, 1, 1, 0, 1, 1, 0);
    @(negedge clk);
    compare();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule